// File: doc/BRIEF.md
# Wrapping Two's Complement Accumulator

The block sums a stream of signed two's complement samples of `SAMPLE_W` bits into a register of the same width that simply wraps when an addition leaves the representable range. Beside it runs a wider guard accumulator of `GUARD_W = SAMPLE_W + ceil(log2(MAX_SAMPLES))` bits. That width holds the exact total of up to `MAX_SAMPLES` samples between clears.

Each addition's overflow is judged from the two carries around the sign bit. A sticky flag records whether any intermediate sum wrapped. Wrapping along the way does not by itself spoil the result. The block therefore also reports whether the final narrow total still equals the exact total, which holds whenever the true sum fits the narrow range. A small controller tracks three named states. `ST_EMPTY` is entered on clear. `ST_CLEAN` is reached when a sample is accepted without overflow. `ST_WRAPPED` is reached from either of the other two states when an accepted sample overflows, and the controller stays there until clear. The clear transition leads from every state to `ST_EMPTY`.

Top module: `wrap_accum`

## Requirements
- R1: One clock edge with `clr` high leaves `sum_wrap` = 0, `sum_full` = 0, `step_ovf` = 0, `ovf_seen` = 0 and `total_ok` = 1.
- R2: A sample accepted (`in_vld` high, `clr` low) at an edge makes `sum_wrap` equal to the previous `sum_wrap` plus the sample, modulo 2^SAMPLE_W, right after that edge.
- R3: `step_ovf` is high for exactly the cycle after an accepted sample whose addition overflowed. Overflow means that the carry into the sign bit differs from the carry out of it, which is the same as the signed result leaving [-2^(SAMPLE_W-1), 2^(SAMPLE_W-1)-1]. When the two carries match, the carry out is dropped and `step_ovf` stays low.
- R4: `ovf_seen` rises after the first overflowing addition and stays high until a clear.
- R5: `sum_full`, read as a signed `GUARD_W`-bit value, equals the exact sum of all samples accepted since the last clear. This holds for up to `MAX_SAMPLES` samples, including `MAX_SAMPLES` copies of the most negative sample.
- R6: `total_ok` is high exactly when the exact sum lies in [-2^(SAMPLE_W-1), 2^(SAMPLE_W-1)-1], that is, when `sum_wrap` sign-extended equals `sum_full`. With SAMPLE_W=4, +6,+7,-7 ends at +6 with `total_ok` = 1, while +6,+7,-5 ends with `total_ok` = 0.
- R7: In a cycle with `in_vld` low and `clr` low, `sum_wrap`, `sum_full` and `ovf_seen` hold their values and `step_ovf` goes low.
- R8: `clr` takes precedence over `in_vld`: a sample presented together with `clr` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear of sums, flags and state |
| in_vld | input | 1 | Sample strobe; sample is added when high |
| in_smp | input | SAMPLE_W | Signed sample |
| sum_wrap | output | SAMPLE_W | Narrow running sum, wraps on overflow |
| step_ovf | output | 1 | Last accepted addition overflowed |
| ovf_seen | output | 1 | Sticky: some addition since clear overflowed |
| sum_full | output | GUARD_W | Exact running sum, signed |
| total_ok | output | 1 | Narrow sum equals the exact sum |

## Verification
The assertions check four relations on every cycle: that the low bits of the guard sum always agree with the narrow sum, that the sticky flag never drops without a clear, that idle cycles leave the sums unchanged, and that a wrong total implies a recorded overflow. Whether each narrow sum is the correct modular value, and whether the overflow flag agrees with the carry rule for a given sample, can only be shown by the bench. The bench runs random sample streams against its own integer model of the exact sum, plus the directed wrap-and-recover, boundary and full-length negative cases.

// File: rtl/wrap_accum_pkg.sv
package wrap_accum_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,  // cleared, nothing accepted
        ST_CLEAN   = 2'd1,  // samples accepted, no overflow so far
        ST_WRAPPED = 2'd2   // at least one addition overflowed
    } acc_state_t;

endpackage

// File: rtl/wa_sign_adder.sv
// Narrow two's complement adder; overflow from the carries around the sign bit.
module wa_sign_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] sum_out,
    output logic         ovf
);
    localparam int LOW_W = W - 1;

    logic [LOW_W:0] low_sum;   // magnitude bits plus carry into sign
    logic           c_sign;
    logic [1:0]     top_sum;   // sign bit plus carry out

    always_comb begin
        low_sum = {1'b0, a_in[LOW_W-1:0]} + {1'b0, b_in[LOW_W-1:0]};
        c_sign  = low_sum[LOW_W];
        top_sum = {1'b0, a_in[W-1]} + {1'b0, b_in[W-1]} + {1'b0, c_sign};
        sum_out = {top_sum[0], low_sum[LOW_W-1:0]};
        ovf     = c_sign ^ top_sum[1];
    end
endmodule

// File: rtl/wa_guard_acc.sv
// Wide accumulator that never overflows within its sample budget.
module wa_guard_acc #(
    parameter int W = 8,
    parameter int G = 16
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] smp,
    output logic [G-1:0] acc
);
    localparam int EXT = G - W;

    logic [G-1:0] smp_ext;
    logic [G-1:0] acc_q;

    generate
        if (EXT == 0) begin : g_noext
            assign smp_ext = smp;
        end else begin : g_ext
            assign smp_ext = {{EXT{smp[W-1]}}, smp};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr)
            acc_q <= '0;
        else if (en)
            acc_q <= acc_q + smp_ext;
    end

    assign acc = acc_q;
endmodule

// File: rtl/wa_ctrl.sv
// Overflow tracking controller.
module wa_ctrl
    import wrap_accum_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic take,
    input  logic add_ovf,
    output logic acc_en,
    output logic step_ovf,
    output logic ovf_seen
);
    acc_state_t state_q, state_d;
    logic       step_q;

    // State register
    always_ff @(posedge clk) begin
        if (clr)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (take)
                    state_d = add_ovf ? ST_WRAPPED : ST_CLEAN;
            end
            ST_CLEAN: begin
                if (take && add_ovf)
                    state_d = ST_WRAPPED;
            end
            ST_WRAPPED: state_d = ST_WRAPPED;
            default:    state_d = ST_EMPTY;
        endcase
    end

    // Per-addition flag, one cycle after the sample
    always_ff @(posedge clk) begin
        if (clr)
            step_q <= 1'b0;
        else
            step_q <= take & add_ovf;
    end

    // Outputs
    always_comb begin
        acc_en   = take & ~clr;
        step_ovf = step_q;
        ovf_seen = (state_q == ST_WRAPPED);
    end
endmodule

// File: rtl/wrap_accum.sv
// Wrapping accumulator with exact guard sum and final-result check.
module wrap_accum #(
    parameter int SAMPLE_W    = 8,
    parameter int MAX_SAMPLES = 256,
    localparam int GUARD_W    = SAMPLE_W + $clog2(MAX_SAMPLES)
) (
    input  logic                clk,
    input  logic                clr,
    input  logic                in_vld,
    input  logic [SAMPLE_W-1:0] in_smp,
    output logic [SAMPLE_W-1:0] sum_wrap,
    output logic                step_ovf,
    output logic                ovf_seen,
    output logic [GUARD_W-1:0]  sum_full,
    output logic                total_ok
);
    localparam int EXT = GUARD_W - SAMPLE_W;

    logic [SAMPLE_W-1:0] wrap_q;
    logic [SAMPLE_W-1:0] add_sum;
    logic                add_ovf;
    logic                acc_en;

    wa_sign_adder #(.W(SAMPLE_W)) u_add (
        .a_in   (wrap_q),
        .b_in   (in_smp),
        .sum_out(add_sum),
        .ovf    (add_ovf)
    );

    wa_ctrl u_ctrl (
        .clk     (clk),
        .clr     (clr),
        .take    (in_vld),
        .add_ovf (add_ovf),
        .acc_en  (acc_en),
        .step_ovf(step_ovf),
        .ovf_seen(ovf_seen)
    );

    wa_guard_acc #(.W(SAMPLE_W), .G(GUARD_W)) u_guard (
        .clk(clk),
        .clr(clr),
        .en (acc_en),
        .smp(in_smp),
        .acc(sum_full)
    );

    always_ff @(posedge clk) begin
        if (clr)
            wrap_q <= '0;
        else if (acc_en)
            wrap_q <= add_sum;
    end

    assign sum_wrap = wrap_q;

    // Final total is right when the narrow sum, sign-extended, is the exact sum
    generate
        if (EXT == 0) begin : g_same
            assign total_ok = 1'b1;
        end else begin : g_cmp
            assign total_ok = (sum_full == {{EXT{wrap_q[SAMPLE_W-1]}}, wrap_q});
        end
    endgenerate
endmodule

// File: rtl/wrap_accum_chk.sv
module wrap_accum_chk #(
    parameter int SAMPLE_W = 8,
    parameter int GUARD_W  = 16
) (
    input logic                clk,
    input logic                clr,
    input logic                in_vld,
    input logic [SAMPLE_W-1:0] sum_wrap,
    input logic                step_ovf,
    input logic                ovf_seen,
    input logic [GUARD_W-1:0]  sum_full,
    input logic                total_ok
);
    // R1: clear empties sums and flags
    a_r1_clear_state: assert property (@(posedge clk) disable iff (clr === 1'bx)
        clr |=> (sum_wrap == '0 && sum_full == '0 && !step_ovf && !ovf_seen));

    // R2 / R5: narrow and wide sums agree in their low bits
    a_r5_low_bits_agree: assert property (@(posedge clk) disable iff (clr)
        sum_full[SAMPLE_W-1:0] == sum_wrap);

    // R3: a per-addition overflow is always recorded in the sticky flag
    a_r3_step_recorded: assert property (@(posedge clk) disable iff (clr)
        step_ovf |-> ovf_seen);

    // R4: sticky flag holds until clear
    a_r4_sticky_holds: assert property (@(posedge clk) disable iff (clr)
        ovf_seen |=> ovf_seen);

    // R6: a wrong total is only possible after some overflow
    a_r6_bad_needs_ovf: assert property (@(posedge clk) disable iff (clr)
        !total_ok |-> ovf_seen);

    // R7: idle cycles hold the sums and drop the step flag
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (clr)
        !in_vld |=> ($stable(sum_wrap) && $stable(sum_full) && !step_ovf));
endmodule

bind wrap_accum wrap_accum_chk #(.SAMPLE_W(SAMPLE_W), .GUARD_W(GUARD_W)) u_chk (
    .clk     (clk),
    .clr     (clr),
    .in_vld  (in_vld),
    .sum_wrap(sum_wrap),
    .step_ovf(step_ovf),
    .ovf_seen(ovf_seen),
    .sum_full(sum_full),
    .total_ok(total_ok)
);

// File: tb/sim_wrap_accum.sv
module sim_wrap_accum;
    localparam int PERIOD = 10;
    localparam int SW     = 4;
    localparam int MS     = 16;
    localparam int GW     = SW + $clog2(MS);
    localparam int HI     = (1 << (SW - 1)) - 1;
    localparam int LO     = -(1 << (SW - 1));
    localparam int WD_CYC = 50000;

    logic          clk = 1'b0;
    logic          clr = 1'b1;
    logic          in_vld = 1'b0;
    logic [SW-1:0] in_smp = '0;
    logic [SW-1:0] sum_wrap;
    logic          step_ovf, ovf_seen, total_ok;
    logic [GW-1:0] sum_full;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Bench model
    int  m_full;
    int  m_wrap;
    bit  m_step;
    bit  m_seen;

    always #(PERIOD/2) clk = ~clk;

    wrap_accum #(.SAMPLE_W(SW), .MAX_SAMPLES(MS)) u0 (
        .clk(clk), .clr(clr), .in_vld(in_vld), .in_smp(in_smp),
        .sum_wrap(sum_wrap), .step_ovf(step_ovf), .ovf_seen(ovf_seen),
        .sum_full(sum_full), .total_ok(total_ok)
    );

    function automatic int wrap_to(input int v);
        int r;
        r = ((v % (1 << SW)) + (1 << SW)) % (1 << SW);
        if (r > HI) r = r - (1 << SW);
        return r;
    endfunction

    function automatic bit in_range(input int v);
        return (v >= LO) && (v <= HI);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        check({ctx, " R2 sum_wrap"}, int'($signed(sum_wrap)), m_wrap);
        check({ctx, " R3 step_ovf"}, int'(step_ovf), int'(m_step));
        check({ctx, " R4 ovf_seen"}, int'(ovf_seen), int'(m_seen));
        check({ctx, " R5 sum_full"}, int'($signed(sum_full)), m_full);
        check({ctx, " R6 total_ok"}, int'(total_ok), int'(in_range(m_full)));
    endtask

    // One cycle; inputs set at the falling edge, outputs read a quarter period after rising edge
    task automatic cycle(input bit c, input bit v, input int s, input string ctx);
        @(negedge clk);
        clr    = c;
        in_vld = v;
        in_smp = SW'(s);
        @(posedge clk);
        if (c) begin
            m_full = 0; m_wrap = 0; m_step = 0; m_seen = 0;
        end else if (v) begin
            m_step = !in_range(m_wrap + s);
            if (m_step) m_seen = 1;
            m_wrap = wrap_to(m_wrap + s);
            m_full = m_full + s;
        end else begin
            m_step = 0;
        end
        #(PERIOD/4);
        check_all(ctx);
    endtask

    task automatic do_clear();
        cycle(1'b1, 1'b0, 0, "R1 clear");
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_full = 0; m_wrap = 0; m_step = 0; m_seen = 0;
        repeat (2) @(posedge clk);
        do_clear();
        // R1 reset values explicitly
        check("R1 sum_wrap zero", int'(sum_wrap), 0);
        check("R1 total_ok high", int'(total_ok), 1);

        // R6 wrap then recover: +6 +7 -7 -> +6, correct
        cycle(0, 1, 6, "R6 a1");
        cycle(0, 1, 7, "R3 a2 overflow");
        check("R3 step_ovf after +7", int'(step_ovf), 1);
        cycle(0, 1, -7, "R6 a3");
        check("R6 recovered sum", int'($signed(sum_wrap)), 6);
        check("R6 recovered ok", int'(total_ok), 1);

        // R6 wrong result: +6 +7 -5 -> exact 8
        do_clear();
        cycle(0, 1, 6, "R6 b1");
        cycle(0, 1, 7, "R6 b2");
        cycle(0, 1, -5, "R6 b3");
        check("R6 bad total flagged", int'(total_ok), 0);
        check("R5 exact eight", int'($signed(sum_full)), 8);

        // R7 idle hold after overflow
        cycle(0, 0, 5, "R7 idle1");
        cycle(0, 0, -3, "R7 idle2");

        // R8 clear beats valid
        cycle(1, 1, 7, "R8 clr with vld");
        check("R8 sample dropped", int'($signed(sum_full)), 0);

        // Negative boundary: -4 + -4 = -8 no overflow; then -8 overflows
        cycle(0, 1, -4, "R3 n1");
        cycle(0, 1, -4, "R3 n2 no ovf");
        check("R3 no ovf at -8", int'(step_ovf), 0);
        cycle(0, 1, -8, "R3 n3 ovf");

        // R5 full budget of most negative samples
        do_clear();
        for (int i = 0; i < MS; i++) cycle(0, 1, LO, "R5 full neg");
        check("R5 min exact", int'($signed(sum_full)), MS * LO);

        // Random streams
        for (int r = 0; r < 60; r++) begin
            int n;
            do_clear();
            n = 1 + int'($urandom % MS);
            for (int k = 0; k < n; k++) begin
                if (($urandom % 4) == 0) cycle(0, 0, int'($urandom % 16) - 8, "R7 rnd idle");
                cycle(0, 1, int'($urandom % 16) - 8, "R2 rnd");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule